// File: doc/BRIEF.md
# Frame Synchronization Detector and Checker

This block keeps a frame position counter in step with an external synchronizing pulse and then keeps watching that the pulse stays in step. The pulse is captured on the falling edge of the device clock. A rising edge of the captured pulse restarts the counter at frame position zero. The frame lasts one 8 kHz period, so it is 512 device clocks at the slower clock setting and 1024 at the faster one. A rate select input picks between the two.

After the first pulse the block waits for a second pulse exactly one frame later and then declares lock. While locked, it treats two things as loss of lock: a pulse at any other frame position, or a pulse that has not come by one clock after the expected position. Gaining lock and losing lock each set a sticky flag. Each flag has its own acknowledge bit. The interrupt line is high while either flag is set.

Top module: `frame_sync_monitor`

## Requirements
- R1: The sync input is sampled only on the falling clock edge. A pulse that rises after a falling edge and drops before the next falling edge is never seen, and the counter keeps counting.
- R2: A sync event resets frame_count to 0 at the rising clock edge that follows the sampling falling edge. Without an event, frame_count increases by one per clock.
- R3: The frame length L is 512 clocks when rate_sel is 0 and 1024 clocks when rate_sel is 1. frame_count goes from L-1 to 0.
- R4: A sync input held high for several clocks produces one event only, on its rising edge.
- R5: When not locked, a sync event that comes exactly L clocks after the previous event sets in_sync to 1 and sets the lock-gained flag.
- R6: While locked, a sync event at any distance other than L clocks from the previous event clears in_sync and sets the lock-lost flag. That event becomes the new reference.
- R7: While locked, if L+1 clocks pass after the last event with no new event, in_sync clears and the lock-lost flag is set. in_sync stays high through the first L clocks.
- R8: irq_ack bit 0 clears the lock-gained flag and bit 1 clears the lock-lost flag. A flag is set on the same clock as its acknowledge, the set wins. irq is high exactly while either flag is set.
- R9: During reset, frame_count is 0, in_sync is 0 and irq is 0.
- R10: When unlocked, a sync event at the wrong distance sets no flag and becomes the new reference for the next lock attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | External frame synchronizing pulse |
| rate_sel | input | 1 | 0: 512-clock frame, 1: 1024-clock frame |
| irq_ack | input | 2 | Bit 0 clears the lock-gained flag, bit 1 clears the lock-lost flag |
| frame_count | output | 10 | Position within the frame |
| in_sync | output | 1 | High while lock is held |
| irq | output | 1 | High while any status flag is set |

## Verification
The assertions check the following on every clock:
- one event per rising edge of the pulse;
- the counter restarts after each event and wraps at the selected frame length;
- lock and loss events are followed by the matching in_sync and irq values;
- an overdue pulse while locked always produces a loss event;
- a flag that is not acknowledged stays set.

Other behaviour needs the bench's scenarios to show it:
- a glitch that falls between two falling edges is ignored;
- lock is reached only with a spacing of exactly L;
- a misplaced pulse re-arms without a flag when unlocked;
- lock survives the full frame and falls one clock after it.

These scenarios are compared against a cycle model in the bench, using both directed pulse trains and random pulse spacings.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_LOCKED = 2'd2
  } lock_state_t;

  localparam int FLAG_GAIN = 0;
  localparam int FLAG_LOSS = 1;
  localparam int NUM_FLAGS = 2;

  // Frame length in device clocks for the selected clock rate.
  function automatic int unsigned frame_len(input logic fast, input int unsigned base);
    return fast ? base * 2 : base;
  endfunction

endpackage

// File: rtl/fsync_edge_sampler.sv
module fsync_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic pulse_evt
);
  logic smp_q;
  logic smp_d;

  // Capture on the falling edge of the device clock.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= 1'b0;
    else        smp_q <= sync_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_d <= 1'b0;
    else        smp_d <= smp_q;
  end

  assign pulse_evt = smp_q & ~smp_d;
endmodule

// File: rtl/fsync_frame_counter.sv
module fsync_frame_counter #(
  parameter int unsigned BASE_LEN = 512,
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned GAP_W    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_sel,
  input  logic             pulse_evt,
  output logic [CNT_W-1:0] frame_count,
  output logic             aligned,
  output logic             overdue
);
  logic [GAP_W-1:0] len;
  logic [CNT_W-1:0] last_pos;
  logic [CNT_W-1:0] cnt_q;
  logic [GAP_W-1:0] gap_q;

  assign len      = GAP_W'(fsync_pkg::frame_len(rate_sel, BASE_LEN));
  assign last_pos = CNT_W'(len - GAP_W'(1));

  // Wrapping frame position.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (pulse_evt)         cnt_q <= '0;
    else if (cnt_q >= last_pos) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end

  // Saturating distance since the last event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gap_q <= '0;
    else if (pulse_evt)   gap_q <= '0;
    else if (gap_q < len) gap_q <= gap_q + GAP_W'(1);
  end

  assign frame_count = cnt_q;
  assign aligned     = (gap_q == len - GAP_W'(1));
  assign overdue     = (gap_q >= len);
endmodule

// File: rtl/fsync_lock_fsm.sv
module fsync_lock_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_evt,
  input  logic aligned,
  input  logic overdue,
  output logic locked,
  output logic gain_evt,
  output logic lost_evt
);
  import fsync_pkg::*;

  lock_state_t st_q;
  lock_state_t st_n;

  always_comb begin
    st_n     = st_q;
    gain_evt = 1'b0;
    lost_evt = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (pulse_evt) st_n = ST_ARMED;
      end
      ST_ARMED: begin
        if (pulse_evt) begin
          if (aligned) begin
            st_n     = ST_LOCKED;
            gain_evt = 1'b1;
          end
        end else if (overdue) begin
          st_n = ST_HUNT;
        end
      end
      ST_LOCKED: begin
        if (pulse_evt) begin
          if (!aligned) begin
            st_n     = ST_ARMED;
            lost_evt = 1'b1;
          end
        end else if (overdue) begin
          st_n     = ST_HUNT;
          lost_evt = 1'b1;
        end
      end
      default: st_n = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HUNT;
    else        st_q <= st_n;
  end

  assign locked = (st_q == ST_LOCKED);
endmodule

// File: rtl/fsync_event_flags.sv
module fsync_event_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag_q,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q[i] <= 1'b0;
      else if (set[i]) flag_q[i] <= 1'b1;
      else if (clr[i]) flag_q[i] <= 1'b0;
    end
  end

  assign irq = |flag_q;
endmodule

// File: rtl/frame_sync_monitor.sv
module frame_sync_monitor #(
  parameter int unsigned BASE_LEN = 512,
  localparam int unsigned MAX_LEN = 2 * BASE_LEN,
  localparam int unsigned CNT_W   = $clog2(MAX_LEN),
  localparam int unsigned GAP_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             rate_sel,
  input  logic [1:0]       irq_ack,
  output logic [CNT_W-1:0] frame_count,
  output logic             in_sync,
  output logic             irq
);
  import fsync_pkg::*;

  logic                 pulse_evt;
  logic                 aligned;
  logic                 overdue;
  logic                 gain_evt;
  logic                 lost_evt;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_q;

  fsync_edge_sampler u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .pulse_evt (pulse_evt)
  );

  fsync_frame_counter #(
    .BASE_LEN (BASE_LEN),
    .CNT_W    (CNT_W),
    .GAP_W    (GAP_W)
  ) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_sel    (rate_sel),
    .pulse_evt   (pulse_evt),
    .frame_count (frame_count),
    .aligned     (aligned),
    .overdue     (overdue)
  );

  fsync_lock_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_evt (pulse_evt),
    .aligned   (aligned),
    .overdue   (overdue),
    .locked    (in_sync),
    .gain_evt  (gain_evt),
    .lost_evt  (lost_evt)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_GAIN] = gain_evt;
    flag_set[FLAG_LOSS] = lost_evt;
  end

  fsync_event_flags #(.N(NUM_FLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (flag_set),
    .clr    (irq_ack),
    .flag_q (flag_q),
    .irq    (irq)
  );
endmodule

// File: rtl/frame_sync_monitor_sva.sv
module frame_sync_monitor_sva #(
  parameter int unsigned BASE_LEN = 512,
  localparam int unsigned CNT_W   = $clog2(2 * BASE_LEN)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rate_sel,
  input logic [1:0]       irq_ack,
  input logic [CNT_W-1:0] frame_count,
  input logic             in_sync,
  input logic             irq,
  input logic             pulse_evt,
  input logic             overdue,
  input logic             gain_evt,
  input logic             lost_evt,
  input logic [1:0]       flag_q
);
  logic [CNT_W-1:0] last_pos;
  assign last_pos = CNT_W'(fsync_pkg::frame_len(rate_sel, BASE_LEN) - 1);

  assert_single_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_evt |=> !pulse_evt);

  assert_count_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_evt |=> frame_count == '0);

  assert_count_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_evt && frame_count == last_pos) |=> frame_count == '0);

  assert_gain_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gain_evt |=> (in_sync && irq));

  assert_loss_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lost_evt |=> (!in_sync && irq));

  assert_overdue_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && overdue && !pulse_evt) |-> lost_evt);

  assert_gain_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !irq_ack[0]) |=> flag_q[0]);

  assert_loss_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && !irq_ack[1]) |=> flag_q[1]);
endmodule

bind frame_sync_monitor frame_sync_monitor_sva #(.BASE_LEN(BASE_LEN)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .rate_sel    (rate_sel),
  .irq_ack     (irq_ack),
  .frame_count (frame_count),
  .in_sync     (in_sync),
  .irq         (irq),
  .pulse_evt   (pulse_evt),
  .overdue     (overdue),
  .gain_evt    (gain_evt),
  .lost_evt    (lost_evt),
  .flag_q      (flag_q)
);

// File: tb/frame_sync_monitor_test.sv
module frame_sync_monitor_test;
  localparam int BASE = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_in = 1'b0;
  logic       rate_sel = 1'b0;
  logic [1:0] irq_ack = 2'b00;
  logic [9:0] frame_count;
  logic       in_sync;
  logic       irq;

  always #4 clk = ~clk;

  frame_sync_monitor #(.BASE_LEN(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .rate_sel(rate_sel),
    .irq_ack(irq_ack), .frame_count(frame_count), .in_sync(in_sync), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference model: 0 hunt, 1 armed, 2 locked
  int m_st = 0, m_since = 0, m_cnt = 0;
  bit m_g = 0, m_l = 0, m_ps = 0;

  function automatic int flen(bit fast);
    return fast ? 2 * BASE : BASE;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge(bit s, bit [1:0] a);
    int L = flen(rate_sel);
    bit evt = s && !m_ps;
    bit al = (m_since == L - 1);
    bit ov = (m_since >= L);
    bit gain = 0, lost = 0;
    case (m_st)
      0: if (evt) m_st = 1;
      1: if (evt) begin
           if (al) begin m_st = 2; gain = 1; end
         end else if (ov) m_st = 0;
      default: if (evt) begin
           if (!al) begin m_st = 1; lost = 1; end
         end else if (ov) begin m_st = 0; lost = 1; end
    endcase
    m_since = evt ? 0 : (m_since >= L ? m_since : m_since + 1);
    m_cnt   = evt ? 0 : (m_cnt >= L - 1 ? 0 : m_cnt + 1);
    m_g = gain | (m_g & !a[0]);
    m_l = lost | (m_l & !a[1]);
    m_ps = s;
  endtask

  task automatic compare_all();
    chk("R2 frame_count", int'(frame_count), m_cnt);
    chk("R5 in_sync", int'(in_sync), (m_st == 2) ? 1 : 0);
    chk("R8 irq", int'(irq), (m_g | m_l) ? 1 : 0);
  endtask

  task automatic step(bit s, bit [1:0] a);
    sync_in = s;
    irq_ack = a;
    @(posedge clk);
    #1;
    model_edge(s, a);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'b00);
  endtask

  // Pulse that rises after a falling edge and drops before the next one.
  task automatic step_glitch();
    sync_in = 1'b0;
    irq_ack = 2'b00;
    #4 sync_in = 1'b1;
    #2 sync_in = 1'b0;
    @(posedge clk);
    #1;
    model_edge(1'b0, 2'b00);
    compare_all();
  endtask

  task automatic rand_train(int gap, int width);
    for (int i = 0; i < gap; i++) begin
      bit [1:0] a = {($urandom % 20) == 0, ($urandom % 20) == 0};
      step(i < width, a);
    end
  endtask

  initial begin
    int seed = 7;
    void'($urandom(seed));
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset frame_count", int'(frame_count), 0);
    chk("R9 reset in_sync", int'(in_sync), 0);
    chk("R9 reset irq", int'(irq), 0);
    rst_n = 1'b1;

    idle(5);
    step_glitch();
    chk("R1 glitch ignored", int'(frame_count), 6);

    // First reference pulse held high for 5 clocks
    step(1'b1, 2'b00);
    chk("R2 restart at zero", int'(frame_count), 0);
    for (int i = 0; i < 4; i++) step(1'b1, 2'b00);
    chk("R4 held level counts on", int'(frame_count), 4);
    idle(BASE - 5);

    // Second pulse one frame later, acknowledge of gain held at the same time
    step(1'b1, 2'b01);
    chk("R5 lock gained", int'(in_sync), 1);
    chk("R8 set beats ack", int'(irq), 1);
    step(1'b0, 2'b10);
    chk("R8 other ack no effect", int'(irq), 1);
    step(1'b0, 2'b01);
    chk("R8 ack clears", int'(irq), 0);
    idle(BASE - 3);
    step(1'b1, 2'b00);
    chk("R5 stays locked", int'(in_sync), 1);
    chk("R5 no new irq", int'(irq), 0);

    // Misplaced pulse while locked
    idle(299);
    step(1'b1, 2'b00);
    chk("R6 lock lost", int'(in_sync), 0);
    chk("R6 loss irq", int'(irq), 1);
    step(1'b0, 2'b10);
    chk("R8 loss ack", int'(irq), 0);

    // Misplaced pulse while armed, then aligned from it
    idle(98);
    step(1'b1, 2'b00);
    chk("R10 no lock", int'(in_sync), 0);
    chk("R10 no flag", int'(irq), 0);
    idle(BASE - 1);
    step(1'b1, 2'b00);
    chk("R10 relock from new reference", int'(in_sync), 1);
    step(1'b0, 2'b01);

    // Missing pulse
    idle(BASE - 1);
    chk("R7 no early loss", int'(in_sync), 1);
    step(1'b0, 2'b00);
    chk("R7 lock lost on timeout", int'(in_sync), 0);
    chk("R7 loss irq", int'(irq), 1);
    step(1'b0, 2'b10);

    // Faster clock setting
    rate_sel = 1'b1;
    step(1'b1, 2'b00);
    idle(2 * BASE - 1);
    chk("R3 count reaches 1023", int'(frame_count), 1023);
    step(1'b1, 2'b00);
    chk("R3 lock at 1024", int'(in_sync), 1);
    step(1'b0, 2'b01);

    // Random pulse spacing on both rates
    for (int r = 0; r < 2; r++) begin
      rate_sel = r[0];
      for (int p = 0; p < 25; p++) begin
        int L = flen(rate_sel);
        int sel = int'($urandom % 8);
        int gap;
        int width = 1 + int'($urandom % 3);
        if (sel < 5)       gap = L;
        else if (sel == 5) gap = (($urandom % 2) == 0) ? L - 1 : L + 1;
        else if (sel == 6) gap = 4 + int'($urandom % (L - 8));
        else               gap = L + 3;
        rand_train(gap, width);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule